// File: doc/BRIEF.md
# Receiver Standby Wakeup Controller

This block sits beside an existing serial receiver and manages its standby state. Software asks for standby by writing a request bit. While that bit is set, every receiver interrupt is held off and frames are dropped. The block watches the serial line on baud ticks and watches the frame-complete strobes from the receiver. When the chosen wake condition appears, it leaves standby and clears the request bit in hardware.

A run-time select picks one of two wake methods. In idle mode, the block wakes after one full character time of unbroken high samples on the line. In address mode, it wakes on a received character whose top data bit is set. That character is delivered as normal data. The block also holds the receiver enable, which is guarded by the global enable. It holds the receive-full flag, and clearing the receiver enable does not touch that flag.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After reset, standby_o, rx_en_o, rx_full_o, rx_valid_o and irq_o are all 0.
- R2: Writing sby_wdata_i=1 with sby_wr_i sets standby_o on the next clock edge. While standby_o is 1, irq_mask_o is 1 and irq_o is 0, whatever irq_req_i and rx_full_o are.
- R3: While standby_o is 0, irq_o is 1 exactly when any bit of irq_req_i is 1 or rx_full_o is 1.
- R4: With rx_en_o=1 and standby_o=0, a frame_done_i strobe makes rx_valid_o pulse for one cycle after the edge, with rx_data_o equal to the frame data, and sets rx_full_o. rx_full_clr_i clears rx_full_o. A frame that arrives while rx_en_o=0 is dropped.
- R5: Clearing rx_en_o leaves rx_full_o unchanged.
- R6: Writes to rx_en_o have no effect while glb_en_i is 0.
- R7: With wake_sel_i=0 (idle mode), standby_o clears on the edge that takes the CHAR_BITS*SAMPLES_PER_BIT-th consecutive high line sample (baud_tick_i=1, rxd_i=1). Counting restarts at the write that sets standby and at any low sample. Frames that arrive during idle-mode standby are dropped.
- R8: With wake_sel_i=1 (address mode), a frame whose bit DATA_W-1 is 1 clears standby_o and is delivered as in R4. A frame with that bit 0 is dropped and standby stays set. An idle line does not wake the block in this mode.
- R9: A software write that sets standby in the same cycle as a wake condition wins, so standby_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable; gates receiver enable writes |
| rx_en_wr_i | input | 1 | Write strobe for receiver enable |
| rx_en_wdata_i | input | 1 | Receiver enable write value |
| sby_wr_i | input | 1 | Write strobe for standby request |
| sby_wdata_i | input | 1 | Standby request write value |
| wake_sel_i | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| baud_tick_i | input | 1 | Line sample strobe |
| rxd_i | input | 1 | Serial line level |
| frame_done_i | input | 1 | Received frame strobe |
| frame_data_i | input | DATA_W | Received frame data |
| rx_full_clr_i | input | 1 | Clears the receive-full flag |
| irq_req_i | input | N_IRQ | Receiver interrupt requests |
| rx_en_o | output | 1 | Receiver enable |
| standby_o | output | 1 | Standby request and state |
| irq_mask_o | output | 1 | High while interrupts are masked |
| irq_o | output | 1 | Combined receiver interrupt |
| rx_valid_o | output | 1 | One-cycle pulse for a delivered frame |
| rx_data_o | output | DATA_W | Delivered frame data |
| rx_full_o | output | 1 | Receive-full flag |

## Verification
The hardest case to reach from the ports is a software standby write that lands in the same cycle as a wake condition. The stimulus sets address mode and standby, then drives a marked frame and the standby write on the same clock edge. The exact idle threshold is also hard to hit. The line is held high for one sample fewer than a character time, with a low sample placed earlier to prove the restart, and the bench checks that standby drops only on the next sample.

// File: rtl/rx_wake_pkg.sv
package rx_wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_mode_e;
endpackage

// File: rtl/rx_wake_idle.sv
module rx_wake_idle #(
  parameter int unsigned IDLE_TICKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic tick_i,
  input  logic line_i,
  output logic idle_hit_o
);
  localparam int unsigned CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_TICKS);

  logic [CW-1:0] cnt_q;

  assign idle_hit_o = en_i & ~restart_i & tick_i & line_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!line_i)            cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;  // saturate: one hit per idle run
    end
  end

  AST_IDLE_HIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_hit_o |=> !idle_hit_o); // R7
endmodule

// File: rtl/rx_wake_regs.sv
module rx_wake_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic glb_en_i,
  input  logic rx_en_wr_i,
  input  logic rx_en_wdata_i,
  input  logic sby_wr_i,
  input  logic sby_wdata_i,
  input  logic wake_i,
  output logic rx_en_o,
  output logic standby_o,
  output logic sby_set_o
);
  assign sby_set_o = sby_wr_i & sby_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rx_en_o <= 1'b0;
    else if (rx_en_wr_i && glb_en_i) rx_en_o <= rx_en_wdata_i;
  end

  // software write outranks hardware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       standby_o <= 1'b0;
    else if (sby_wr_i) standby_o <= sby_wdata_i;
    else if (wake_i)   standby_o <= 1'b0;
  end

  AST_RXEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> $stable(rx_en_o)); // R6
  AST_SW_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sby_wr_i && sby_wdata_i) |=> standby_o); // R9
endmodule

// File: rtl/rx_wake_deliver.sv
module rx_wake_deliver #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              full_clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= accept_i;
      if (accept_i) data_o <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         full_o <= 1'b0;
    else if (accept_i)   full_o <= 1'b1;
    else if (full_clr_i) full_o <= 1'b0;
  end

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !full_clr_i) |=> $stable(full_o)); // R5
  AST_VALID_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> full_o); // R4
endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl
  import rx_wake_pkg::*;
#(
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned N_IRQ           = 3,
  parameter int unsigned CHAR_BITS       = 10,
  parameter int unsigned SAMPLES_PER_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic              rx_en_wr_i,
  input  logic              rx_en_wdata_i,
  input  logic              sby_wr_i,
  input  logic              sby_wdata_i,
  input  logic              wake_sel_i,
  input  logic              baud_tick_i,
  input  logic              rxd_i,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              rx_full_clr_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  output logic              rx_en_o,
  output logic              standby_o,
  output logic              irq_mask_o,
  output logic              irq_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  localparam int unsigned IDLE_TICKS = CHAR_BITS * SAMPLES_PER_BIT;

  wake_mode_e mode;
  logic idle_hit, sby_set, mark, wake, accept;

  assign mode = wake_mode_e'(wake_sel_i);
  assign mark = frame_done_i & frame_data_i[DATA_W-1];

  always_comb begin
    wake = 1'b0;
    if (standby_o && rx_en_o) begin
      case (mode)
        WAKE_IDLE: wake = idle_hit;
        WAKE_ADDR: wake = mark;
        default:   wake = 1'b0;
      endcase
    end
  end

  // address mark character is delivered even though it arrives in standby
  assign accept = frame_done_i & rx_en_o &
                  (~standby_o | ((mode == WAKE_ADDR) & mark));

  rx_wake_regs u_regs (
    .clk_i, .rst_ni, .glb_en_i, .rx_en_wr_i, .rx_en_wdata_i,
    .sby_wr_i, .sby_wdata_i,
    .wake_i    (wake),
    .rx_en_o,
    .standby_o,
    .sby_set_o (sby_set)
  );

  rx_wake_idle #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk_i, .rst_ni,
    .en_i       (rx_en_o),
    .restart_i  (sby_set),
    .tick_i     (baud_tick_i),
    .line_i     (rxd_i),
    .idle_hit_o (idle_hit)
  );

  rx_wake_deliver #(.DATA_W(DATA_W)) u_deliver (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .data_i     (frame_data_i),
    .full_clr_i (rx_full_clr_i),
    .valid_o    (rx_valid_o),
    .data_o     (rx_data_o),
    .full_o     (rx_full_o)
  );

  assign irq_mask_o = standby_o;
  assign irq_o      = ~standby_o & ((|irq_req_i) | rx_full_o);

  AST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !irq_o); // R2
  AST_ADDR_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && rx_en_o && wake_sel_i && mark && !sby_wr_i)
    |=> (!standby_o && rx_valid_o)); // R8
  AST_IDLE_NO_ADDR_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && wake_sel_i && !frame_done_i && !sby_wr_i) |=> standby_o); // R8
endmodule

// File: tb/rx_wake_ctrl_tb_top.sv
module rx_wake_ctrl_tb_top;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_IRQ  = 3;
  localparam int unsigned IDLE   = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic glb_en = 0, rx_en_wr = 0, rx_en_wdata = 0, sby_wr = 0, sby_wdata = 0;
  logic wake_sel = 0, tick = 0, rxd = 1, frame_done = 0, full_clr = 0;
  logic [DATA_W-1:0] frame_data = '0;
  logic [N_IRQ-1:0]  irq_req = '0;
  logic rx_en, standby, irq_mask, irq, valid, full;
  logic [DATA_W-1:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .glb_en_i(glb_en), .rx_en_wr_i(rx_en_wr),
    .rx_en_wdata_i(rx_en_wdata), .sby_wr_i(sby_wr), .sby_wdata_i(sby_wdata),
    .wake_sel_i(wake_sel), .baud_tick_i(tick), .rxd_i(rxd),
    .frame_done_i(frame_done), .frame_data_i(frame_data),
    .rx_full_clr_i(full_clr), .irq_req_i(irq_req), .rx_en_o(rx_en),
    .standby_o(standby), .irq_mask_o(irq_mask), .irq_o(irq),
    .rx_valid_o(valid), .rx_data_o(rdata), .rx_full_o(full)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_rx_en(logic v);
    rx_en_wr = 1; rx_en_wdata = v; cyc(); rx_en_wr = 0;
  endtask

  task automatic wr_sby(logic v);
    sby_wr = 1; sby_wdata = v; cyc(); sby_wr = 0;
  endtask

  task automatic frame(logic [DATA_W-1:0] d);
    frame_done = 1; frame_data = d; cyc(); frame_done = 0;
  endtask

  task automatic clr_full();
    full_clr = 1; cyc(); full_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 standby", standby, 0);
    chk("R1 rx_en", rx_en, 0);
    chk("R1 full", full, 0);
    chk("R1 valid", valid, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rx_en_lock();
    glb_en = 0; wr_rx_en(1);
    chk("R6 write ignored", rx_en, 0);
    glb_en = 1; wr_rx_en(1);
    chk("R6 write taken", rx_en, 1);
  endtask

  task automatic t_normal();
    frame(8'h5C);
    chk("R4 valid", valid, 1);
    chk("R4 data", rdata, 8'h5C);
    chk("R4 full", full, 1);
    cyc();
    chk("R4 valid pulse", valid, 0);
    chk("R3 irq from full", irq, 1);
    clr_full();
    chk("R4 full cleared", full, 0);
    chk("R3 irq idle", irq, 0);
    irq_req = 3'b010; cyc();
    chk("R3 irq from req", irq, 1);
    irq_req = '0;
  endtask

  task automatic t_full_hold();
    frame(8'h11);
    wr_rx_en(0);
    chk("R5 rx_en off", rx_en, 0);
    chk("R5 full kept", full, 1);
    clr_full();
    frame(8'h22);
    chk("R4 dropped when off", valid, 0);
    chk("R4 full stays clear", full, 0);
    wr_rx_en(1);
  endtask

  task automatic t_mask();
    irq_req = 3'b101;
    wr_sby(1);
    chk("R2 standby set", standby, 1);
    chk("R2 mask", irq_mask, 1);
    chk("R2 irq masked", irq, 0);
    irq_req = '0;
    wr_sby(0);
    chk("R2 standby cleared by write", standby, 0);
  endtask

  task automatic t_idle_wake();
    wake_sel = 0; rxd = 1; tick = 0;
    wr_sby(1);
    frame(8'hF0);
    chk("R7 frame dropped", valid, 0);
    chk("R7 full unchanged", full, 0);
    tick = 1;
    cyc(20);
    rxd = 0; cyc(); rxd = 1;
    cyc(IDLE - 1);
    chk("R7 not yet awake", standby, 1);
    cyc();
    chk("R7 idle wake", standby, 0);
    tick = 0;
  endtask

  task automatic t_addr_wake();
    wake_sel = 1; rxd = 1;
    wr_sby(1);
    frame(8'h35);
    chk("R8 unmarked dropped", valid, 0);
    chk("R8 still standby", standby, 1);
    tick = 1; cyc(IDLE + 10); tick = 0;
    chk("R8 idle no wake", standby, 1);
    frame(8'hA7);
    chk("R8 wake", standby, 0);
    chk("R8 delivered", valid, 1);
    chk("R8 data", rdata, 8'hA7);
    chk("R8 full", full, 1);
    clr_full();
  endtask

  task automatic t_priority();
    wake_sel = 1;
    wr_sby(1);
    sby_wr = 1; sby_wdata = 1; frame_done = 1; frame_data = 8'h81;
    cyc();
    sby_wr = 0; frame_done = 0;
    chk("R9 software wins", standby, 1);
    wr_sby(0);
    clr_full();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_ni = 1; cyc();
    t_reset();
    t_rx_en_lock();
    t_normal();
    t_full_hold();
    t_mask();
    t_idle_wake();
    t_addr_wake();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule